// File: doc/BRIEF.md
# Open-Drain Serial Frame Transmitter

This block sends asynchronous serial frames on a single line that is wired open-drain. The block never drives the line high. Its data output `tx_dat` is held at 0. The block sends a bit by setting the enable `tx_release`:
- `tx_release = 0` turns the driver on and pulls the line low, which is a logic 0.
- `tx_release = 1` puts the driver in high-Z. A pull-up outside the block then makes the line read high, which is a logic 1 or the idle (mark) level.

A word is offered with a valid/ready handshake. Each frame has these parts, in this order:
1. One start bit, at logic 0.
2. The data bits, least significant bit first.
3. An optional parity bit.
4. The stop bits, at logic 1.

The data length, the parity mode and the stop-bit count are inputs. The block samples them once, in the cycle it accepts the word. The bit period is a whole number of clock cycles. It is computed at elaboration from the clock frequency and the baud rate parameters. Typical settings are 8 data bits, no parity and 1 stop bit.

Top module: `od_uart_tx`

## Requirements
- R1: After reset, `tx_release` is 1, `in_ready` is 1 and the block is idle. While `in_ready` is 1, `tx_release` stays 1.
- R2: A word is accepted at a rising clock edge where `in_valid` and `in_ready` are both 1. From the next cycle, `in_ready` stays 0 for exactly N×DIV cycles, where N is the number of bits in the frame. `in_valid` has no effect while `in_ready` is 0.
- R3: DIV is CLK_HZ/BAUD rounded to the nearest integer. Every bit of the frame holds the line for exactly DIV cycles. The line changes only at bit boundaries.
- R4: The cycle after acceptance starts the start bit (`tx_release` = 0). The data bits follow with `in_data[0]` first.
- R5: `cfg_len` sets the number of data bits, from 5 to 9. A value below 5 acts as 5 and a value above 9 acts as 9. Bits of `in_data` at or above the data length are ignored.
- R6: `cfg_parity` selects the parity bit, which is sent right after the data bits:
  - 0 = even: the count of ones over the data and parity bits is even.
  - 1 = odd: that count is odd.
  - 2 or 3 = no parity bit.
- R7: `cfg_stop` sets the number of stop bits, from 1 to 3, and 0 acts as 1. Every stop bit is sent as `tx_release` = 1.
- R8: The configuration inputs are sampled only in the cycle of acceptance. A change to them during a frame has no effect on that frame.
- R9: `tx_dat` is 0 at all times. A logic 0 on the line is always sent as `tx_release` = 0, and a logic 1 is always sent as `tx_release` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The block is idle and can accept a word |
| in_data | input | 9 | Word to send, LSB first |
| cfg_len | input | 4 | Number of data bits (5..9, clamped) |
| cfg_parity | input | 2 | 0 = even, 1 = odd, 2/3 = none |
| cfg_stop | input | 2 | Number of stop bits (1..3, 0 acts as 1) |
| tx_dat | output | 1 | Output data value, always 0 |
| tx_release | output | 1 | 1 = driver off (line high), 0 = line driven low |

## Verification
Each kind of wrong internal state shows up at the ports as follows:
- A wrong bit-timer reload makes a bit longer or shorter than DIV cycles. This shifts every later edge of the frame, and the first shifted edge shows within one bit period.
- A wrong shift or bit-count state gives a wrong data bit, or too many or too few data bits. This appears on `tx_release` in the bit slot where it happens.
- A wrongly latched parity or stop setting moves the point where `in_ready` rises, and `in_ready` is checked every cycle against the reference.
- A state that never leaves the frame keeps `in_ready` low. The first cycle in which the reference expects the block to be idle again reports it.

// File: rtl/od_uart_tx.sv
module od_uart_tx #(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 115_200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [8:0] in_data,
  input  logic [3:0] cfg_len,
  input  logic [1:0] cfg_parity,
  input  logic [1:0] cfg_stop,
  output logic       tx_dat,
  output logic       tx_release
);

  localparam int DIV = (CLK_HZ + BAUD / 2) / BAUD;
  localparam int CW  = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(DIV - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} state_t;

  state_t        st;
  logic [CW-1:0] tick;
  logic [8:0]    sh;
  logic [3:0]    nbit;
  logic [1:0]    stop_n;
  logic          par_en, par_q, rel_q;

  logic [3:0] len_eff;
  logic [1:0] stop_eff;
  logic [8:0] mask;
  logic       pbit;

  assign len_eff  = (cfg_len < 4'd5) ? 4'd5 : (cfg_len > 4'd9) ? 4'd9 : cfg_len;
  assign stop_eff = (cfg_stop == 2'd0) ? 2'd1 : cfg_stop;
  assign mask     = 9'h1FF >> (4'd9 - len_eff);
  assign pbit     = ^(in_data & mask) ^ cfg_parity[0];

  assign in_ready   = (st == S_IDLE);
  assign tx_dat     = 1'b0;
  assign tx_release = rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tick   <= '0;
      sh     <= '0;
      nbit   <= '0;
      stop_n <= '0;
      par_en <= 1'b0;
      par_q  <= 1'b0;
      rel_q  <= 1'b1;
    end else if (st == S_IDLE) begin
      if (in_valid) begin
        st     <= S_START;
        tick   <= RELOAD;
        sh     <= in_data & mask;
        nbit   <= len_eff - 4'd1;
        stop_n <= stop_eff - 2'd1;
        par_en <= ~cfg_parity[1];
        par_q  <= pbit;
        rel_q  <= 1'b0;
      end
    end else if (tick != '0) begin
      tick <= tick - 1'b1;
    end else begin
      tick <= RELOAD;
      case (st)
        S_START: begin
          st    <= S_DATA;
          rel_q <= sh[0];
        end
        S_DATA: begin
          if (nbit != 4'd0) begin
            nbit  <= nbit - 4'd1;
            sh    <= sh >> 1;
            rel_q <= sh[1];
          end else if (par_en) begin
            st    <= S_PAR;
            rel_q <= par_q;
          end else begin
            st    <= S_STOP;
            rel_q <= 1'b1;
            nbit  <= {2'b00, stop_n};
          end
        end
        S_PAR: begin
          st    <= S_STOP;
          rel_q <= 1'b1;
          nbit  <= {2'b00, stop_n};
        end
        S_STOP: begin
          if (nbit != 4'd0) begin
            nbit <= nbit - 4'd1;
          end else begin
            st   <= S_IDLE;
            tick <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tx_release); // R1

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!tx_release && !in_ready)); // R4

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick != '0) |=> $stable(tx_release)); // R3

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tick <= RELOAD); // R3

  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP) |-> tx_release); // R7

  AST_DATA_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) |-> (nbit < 4'd9)); // R5

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && tick != '0) |=> !in_ready); // R2

endmodule

// File: tb/test_od_uart_tx.sv
module test_od_uart_tx;
  localparam int CLK_HZ = 1_000_000;
  localparam int BAUD   = 270_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [8:0] in_data = '0;
  logic [3:0] cfg_len = 4'd8;
  logic [1:0] cfg_parity = 2'd2;
  logic [1:0] cfg_stop = 2'd1;
  logic       in_ready, tx_dat, tx_release;

  od_uart_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) i_od_uart_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_len(cfg_len), .cfg_parity(cfg_parity),
    .cfg_stop(cfg_stop), .tx_dat(tx_dat), .tx_release(tx_release));

  always #2 clk = ~clk;

  int    checks = 0;
  int    fails = 0;
  int    div;
  bit    mdl_ready = 1'b1;
  bit    qv[$];
  string qt[$];
  string scen = "reset";

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] at %0t: act=%0d exp=%0d", tag, scen, $time, act, exp);
    end
  endtask

  task automatic push(bit v, string tag);
    for (int i = 0; i < div; i++) begin
      qv.push_back(v);
      qt.push_back(tag);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && in_valid && mdl_ready) begin
      int n, s, ones;
      n = int'(cfg_len);
      if (n < 5) n = 5;
      if (n > 9) n = 9;
      s = (cfg_stop == 0) ? 1 : int'(cfg_stop);
      ones = 0;
      push(1'b0, "R3 start");
      for (int i = 0; i < n; i++) begin
        push(in_data[i], "R4/R5 data");
        ones += int'(in_data[i]);
      end
      if (cfg_parity == 2'd0) push(ones % 2 == 1, "R6 even parity");
      if (cfg_parity == 2'd1) push(ones % 2 == 0, "R6 odd parity");
      for (int i = 0; i < s; i++) push(1'b1, "R7 stop");
      mdl_ready = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 tx_dat", int'(tx_dat), 0);
      if (qv.size() == 0) begin
        chk("R2 ready idle", int'(in_ready), 1);
        chk("R1 idle line", int'(tx_release), 1);
        mdl_ready = 1'b1;
      end else begin
        chk("R2 ready busy", int'(in_ready), 0);
        chk(qt[0], int'(tx_release), int'(qv[0]));
        void'(qv.pop_front());
        void'(qt.pop_front());
        mdl_ready = 1'b0;
      end
    end
  end

  task automatic send(string lbl, logic [8:0] d, logic [3:0] l, logic [1:0] p, logic [1:0] s);
    do begin
      @(negedge clk); #1;
    end while (!mdl_ready);
    scen = lbl;
    in_data = d; cfg_len = l; cfg_parity = p; cfg_stop = s;
    in_valid = 1'b1;
    @(negedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    do begin
      @(negedge clk); #1;
    end while (!mdl_ready);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    div = $rtoi(real'(CLK_HZ) / real'(BAUD) + 0.5);
    repeat (3) @(negedge clk);
    chk("R1 reset release", int'(tx_release), 1);
    chk("R1 reset ready", int'(in_ready), 1);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    send("R4 8N1 0x55", 9'h055, 4'd8, 2'd2, 2'd1); drain();
    send("R6 8E2 0xA3", 9'h0A3, 4'd8, 2'd0, 2'd2); drain();
    send("R6 8O1 0xA3", 9'h0A3, 4'd8, 2'd1, 2'd1); drain();
    send("R6 8E1 0x00", 9'h000, 4'd8, 2'd0, 2'd1); drain();
    send("R5 len5 upper bits", 9'h1FF, 4'd5, 2'd0, 2'd1); drain();
    send("R5 len9 odd 3 stop", 9'h155, 4'd9, 2'd1, 2'd3); drain();
    send("R5 len2 clamps to 5", 9'h1EA, 4'd2, 2'd2, 2'd1); drain();
    send("R5 len15 clamps to 9", 9'h1C3, 4'd15, 2'd0, 2'd1); drain();
    send("R7 stop0 acts as 1", 9'h0F0, 4'd8, 2'd2, 2'd0); drain();
    send("R6 parity3 none", 9'h0B7, 4'd7, 2'd3, 2'd2); drain();

    send("R8 mid-frame config change", 9'h0C9, 4'd8, 2'd0, 2'd1);
    cfg_len = 4'd5; cfg_parity = 2'd1; cfg_stop = 2'd3; in_data = 9'h1FF;
    drain();

    scen = "R2 valid while busy ignored";
    send("R2 valid while busy ignored", 9'h03C, 4'd6, 2'd2, 2'd1);
    repeat (5) begin
      @(negedge clk); #1;
      if (!mdl_ready) begin
        in_data = 9'h1AA; in_valid = 1'b1;
        @(negedge clk); #1;
        in_valid = 1'b0;
      end
    end
    drain();

    scen = "R2 back-to-back valid held";
    in_data = 9'h0E1; cfg_len = 4'd8; cfg_parity = 2'd1; cfg_stop = 2'd1;
    in_valid = 1'b1;
    repeat (100) @(negedge clk);
    #1 in_valid = 1'b0;
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog expired: act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule